// File: doc/BRIEF.md
# Shared Timebase Counter with Capture/Compare Channels

This block is one 16-bit up-counter that serves as the common time reference for five capture/compare channels. A small run-control state machine decides whether the counter may advance. A tick generator supplies the advance pulse from one of four sources: a slow prescaler, a fast prescaler, an overflow pulse from a neighbouring timer, or a falling edge on an external pin. The count is kept as a low byte and a high byte. Software can read and write each byte on its own.

Each channel has a mode byte and two compare bytes. In capture mode it latches the count when its pin shows a chosen edge. In match mode it raises a flag when the count reaches its 16-bit compare value. In toggle mode it does the same and also flips its output pin. In PWM mode it drives a duty-cycle output from the counter low byte. Software reaches every register through a byte-wide port: a write strobe, an address and write data, with read data returned combinationally for the address presented.

The run-control machine has three states:
- STOP: the run bit is clear.
- RUN: the counter is allowed to advance.
- HOLD: the freeze option is set and the idle input is high.

Its transitions are evaluated every clock:
- Any state goes to STOP when the run bit is clear.
- STOP→RUN and HOLD→RUN happen when the run bit is set and the freeze condition is absent.
- STOP→HOLD and RUN→HOLD happen when the run bit is set and the freeze condition is present.

The state follows the control bits one clock after they change.

Top module: `tbase_array`

## Requirements
- R1: After reset, every register reads 0x00 and every `ch_out` bit is 0. Registers outside the map also read 0x00: addresses 0x04–0x07, 0x1C–0x1F and sub-offset 3 of each channel.
- R2: The control register at 0x00 has these fields: bit0 run, bit1 freeze-in-idle, bits3:2 source, bit7 overflow flag. Source 0 advances the counter once every 12 clocks and source 1 once every 4 clocks. The counter advances only while in state RUN.
- R3: With source 2, each clock in which `t0_ovf_i` is high advances the counter by one.
- R4: With source 3, `ext_cnt_i` passes through a two-flop synchronizer. Each 1-to-0 transition advances the counter exactly once, two clocks after the first flop samples the low level. Rising transitions and a steady level do not advance it.
- R5: With the freeze bit set and `idle_i` high, the counter holds its value. With the freeze bit clear, `idle_i` has no effect. With the run bit clear, the counter holds.
- R6: Writing 0x01 replaces the low count byte and writing 0x02 replaces the high count byte. A tick that lands in the same clock as such a write is dropped.
- R7: An advance from 0xFFFF to 0x0000 sets the overflow flag (control bit7). Writing control with bit7 = 0 clears it, and writing bit7 = 1 leaves it as it is. If a set and a clear fall in the same clock, the set wins.
- R8: Channel n sits at 0x08 + 4n: +0 mode, +1 compare low byte, +2 compare high byte. Mode bits2:0 select the function (0 off, 1 capture, 2 match, 3 toggle, 4 PWM). Bit3 enables capture on a rising edge, bit4 enables capture on a falling edge, and bit5 enables match. In capture mode, an enabled edge on the synchronized pin copies the count into the compare bytes in the same clock that the edge is detected. A tick in that clock is seen after the copy. The capture also sets the channel flag, and an edge that is not enabled does nothing.
- R9: In match or toggle mode with bit5 set, a tick that takes the count to the channel's 16-bit compare value sets the channel flag. In toggle mode it also inverts `ch_out[n]`. With bit5 clear, nothing happens.
- R10: In PWM mode, `ch_out[n]` is 0 while the count low byte is below the compare low byte and 1 otherwise. A tick that carries the low byte from 0xFF to 0x00 reloads the compare low byte from the compare high byte.
- R11: The flag register at 0x03 holds one bit per channel (bit n for channel n). Writing it clears each bit written as 0 and keeps each bit written as 1. A flag event in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| idle_i | input | 1 | Device idle indication |
| t0_ovf_i | input | 1 | Overflow pulse from the neighbouring timer |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| ch_in | input | 5 | Channel capture pins (asynchronous) |
| ch_out | output | 5 | Channel toggle/PWM outputs |

## Verification
Two collisions can land in one clock, and the bench provokes each on purpose.

The first is a capture edge arriving in the same clock as a counter tick. The bench lowers a channel pin, then places a single overflow pulse exactly two clocks later, so that edge detection and the tick coincide. It then requires two things: the captured bytes hold the pre-tick count, and the counter holds that count plus one.

The second is a match event arriving in the same clock as a software write that clears flags. The bench issues the clearing write and the final tick in the same cycle. It requires the matching channel's flag to survive while the other flags clear.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_TOVF = 2'd2,
        SRC_PIN  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        CM_OFF     = 3'd0,
        CM_CAPTURE = 3'd1,
        CM_MATCH   = 3'd2,
        CM_TOGGLE  = 3'd3,
        CM_PWM     = 3'd4
    } cmode_e;

    typedef enum logic [1:0] {
        RS_STOP = 2'd0,
        RS_RUN  = 2'd1,
        RS_HOLD = 2'd2
    } run_e;

    localparam int A_CTRL    = 0;
    localparam int A_CNT_LO  = 1;
    localparam int A_CNT_HI  = 2;
    localparam int A_FLAGS   = 3;
    localparam int A_CH_BASE = 8;

endpackage

// File: rtl/tbase_runctl.sv
module tbase_runctl
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic freeze,
    input  logic idle,
    output logic count_en
);

    run_e state_q, state_d;
    logic frz_cond;

    assign frz_cond = freeze && idle;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_STOP: if (run) state_d = frz_cond ? RS_HOLD : RS_RUN;
            RS_RUN: begin
                if (!run)          state_d = RS_STOP;
                else if (frz_cond) state_d = RS_HOLD;
            end
            RS_HOLD: begin
                if (!run)           state_d = RS_STOP;
                else if (!frz_cond) state_d = RS_RUN;
            end
            default: state_d = RS_STOP;
        endcase
    end

    always_comb begin
        count_en = (state_q == RS_RUN);
    end

endmodule

// File: rtl/tbase_tick.sv
module tbase_tick
    import tbase_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  src_e src,
    input  logic t0_pulse,
    input  logic ext_pin,
    output logic tick
);

    localparam int SW = $clog2(DIV_SLOW);
    localparam int FW = $clog2(DIV_FAST);

    logic [SW-1:0] slow_q;
    logic [FW-1:0] fast_q;
    logic [2:0]    ext_q;
    logic          slow_hit, fast_hit, ext_fall;

    assign slow_hit = (slow_q == SW'(DIV_SLOW - 1));
    assign fast_hit = (fast_q == FW'(DIV_FAST - 1));
    assign ext_fall = ext_q[2] && !ext_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= '0;
            fast_q <= '0;
            ext_q  <= '0;
        end else begin
            slow_q <= slow_hit ? '0 : slow_q + SW'(1);
            fast_q <= fast_hit ? '0 : fast_q + FW'(1);
            ext_q  <= {ext_q[1:0], ext_pin};
        end
    end

    always_comb begin
        tick = 1'b0;
        unique case (src)
            SRC_SLOW: tick = slow_hit;
            SRC_FAST: tick = fast_hit;
            SRC_TOVF: tick = t0_pulse;
            SRC_PIN:  tick = ext_fall;
            default:  tick = 1'b0;
        endcase
        tick = tick && en;
    end

endmodule

// File: rtl/tbase_chan.sv
module tbase_chan
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             cnt_adv,
    input  logic             pin_in,
    output logic             evt,
    output logic [7:0]       mode_q,
    output logic [7:0]       lo_q,
    output logic [7:0]       hi_q,
    output logic             pin_out
);

    logic [5:0] mode_r;
    logic [2:0] pin_q;
    logic       tog_q;
    cmode_e     func;
    logic       rise, fall, cap_hit, mt_hit, pwm_rel;

    assign mode_q = {2'b00, mode_r};
    assign func   = cmode_e'(mode_r[2:0]);
    assign rise   = pin_q[1] && !pin_q[2];
    assign fall   = pin_q[2] && !pin_q[1];

    always_comb begin
        cap_hit = 1'b0;
        mt_hit  = 1'b0;
        pwm_rel = 1'b0;
        pin_out = tog_q;
        case (func)
            CM_CAPTURE: cap_hit = (mode_r[3] && rise) || (mode_r[4] && fall);
            CM_MATCH, CM_TOGGLE:
                mt_hit = cnt_adv && mode_r[5] && (cnt_inc == {hi_q, lo_q});
            CM_PWM: begin
                pwm_rel = cnt_adv && (cnt[7:0] == 8'hFF);
                pin_out = (cnt[7:0] >= lo_q);
            end
            default: ;
        endcase
        evt = cap_hit || mt_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pin_q  <= '0;
            tog_q  <= 1'b0;
        end else begin
            pin_q <= {pin_q[1:0], pin_in};
            if (mode_we) mode_r <= wdata[5:0];
            if (lo_we)        lo_q <= wdata;
            else if (cap_hit) lo_q <= cnt[7:0];
            else if (pwm_rel) lo_q <= hi_q;
            if (hi_we)        hi_q <= wdata;
            else if (cap_hit) hi_q <= cnt[CNT_W-1:8];
            if (mt_hit && func == CM_TOGGLE) tog_q <= !tog_q;
        end
    end

endmodule

// File: rtl/tbase_array.sv
module tbase_array
    import tbase_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int ADDR_W   = 5,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              idle_i,
    input  logic              t0_ovf_i,
    input  logic              ext_cnt_i,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] ch_out
);

    localparam int CNT_W = 16;
    localparam int IDX_W = ADDR_W - 2;

    logic              ctrl_run, ctrl_frz, ovf_q;
    src_e              ctrl_src;
    logic [CNT_W-1:0]  cnt_q, cnt_inc;
    logic [NUM_CH-1:0] flag_q, ch_evt;
    logic              cnt_en, tick, cnt_adv;
    logic              wr_ctrl, wr_lo, wr_hi, wr_flag;
    logic [ADDR_W-1:0] ch_off;
    logic              ch_rng;
    logic [IDX_W-1:0]  ch_idx;
    logic [1:0]        ch_sub;
    logic [7:0]        ch_mode [NUM_CH];
    logic [7:0]        ch_lo   [NUM_CH];
    logic [7:0]        ch_hi   [NUM_CH];

    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_lo   = reg_we && (reg_addr == ADDR_W'(A_CNT_LO));
    assign wr_hi   = reg_we && (reg_addr == ADDR_W'(A_CNT_HI));
    assign wr_flag = reg_we && (reg_addr == ADDR_W'(A_FLAGS));
    assign ch_off  = reg_addr - ADDR_W'(A_CH_BASE);
    assign ch_rng  = (reg_addr >= ADDR_W'(A_CH_BASE));
    assign ch_idx  = ch_off[ADDR_W-1:2];
    assign ch_sub  = ch_off[1:0];
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign cnt_adv = tick && !wr_lo && !wr_hi;

    tbase_runctl u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_run),
        .freeze   (ctrl_frz),
        .idle     (idle_i),
        .count_en (cnt_en)
    );

    tbase_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .src      (ctrl_src),
        .t0_pulse (t0_ovf_i),
        .ext_pin  (ext_cnt_i),
        .tick     (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = reg_we && ch_rng && (ch_idx == IDX_W'(g));
        tbase_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_we (sel && ch_sub == 2'd0),
            .lo_we   (sel && ch_sub == 2'd1),
            .hi_we   (sel && ch_sub == 2'd2),
            .wdata   (reg_wdata),
            .cnt     (cnt_q),
            .cnt_inc (cnt_inc),
            .cnt_adv (cnt_adv),
            .pin_in  (ch_in[g]),
            .evt     (ch_evt[g]),
            .mode_q  (ch_mode[g]),
            .lo_q    (ch_lo[g]),
            .hi_q    (ch_hi[g]),
            .pin_out (ch_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_run <= 1'b0;
            ctrl_frz <= 1'b0;
            ctrl_src <= SRC_SLOW;
            ovf_q    <= 1'b0;
            cnt_q    <= '0;
            flag_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_run <= reg_wdata[0];
                ctrl_frz <= reg_wdata[1];
                ctrl_src <= src_e'(reg_wdata[3:2]);
            end
            if (cnt_adv && cnt_q == '1)       ovf_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[7]) ovf_q <= 1'b0;
            if (wr_lo) cnt_q[7:0]       <= reg_wdata;
            if (wr_hi) cnt_q[CNT_W-1:8] <= reg_wdata;
            if (cnt_adv) cnt_q <= cnt_inc;
            flag_q <= (flag_q & (wr_flag ? reg_wdata[NUM_CH-1:0] : '1)) | ch_evt;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL))
            reg_rdata = {ovf_q, 3'b000, ctrl_src, ctrl_frz, ctrl_run};
        else if (reg_addr == ADDR_W'(A_CNT_LO))
            reg_rdata = cnt_q[7:0];
        else if (reg_addr == ADDR_W'(A_CNT_HI))
            reg_rdata = cnt_q[CNT_W-1:8];
        else if (reg_addr == ADDR_W'(A_FLAGS))
            reg_rdata = 8'(flag_q);
        else if (ch_rng) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == IDX_W'(i)) begin
                    case (ch_sub)
                        2'd0:    reg_rdata = ch_mode[i];
                        2'd1:    reg_rdata = ch_lo[i];
                        2'd2:    reg_rdata = ch_hi[i];
                        default: reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/tbase_array_chk.sv
module tbase_array_chk #(
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [15:0]       cnt,
    input logic              cnt_en,
    input logic              cnt_adv,
    input logic              ovf,
    input logic [NUM_CH-1:0] flags
);

    logic cnt_wr;
    assign cnt_wr = reg_we && (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2));

    // R6: without a byte write the count moves by at most one
    a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

    // R5: outside the running state the count is frozen
    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr) |=> $stable(cnt));

    // R7: advance from all ones wraps and raises the overflow flag
    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_adv && cnt == 16'hFFFF) |=> (cnt == 16'h0000 && ovf));

    // R7: overflow flag is sticky without a clearing write
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_we && reg_addr == ADDR_W'(0) && !reg_wdata[7])) |=> ovf);

    // R11: channel flags are sticky without a write to the flag register
    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(3)) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind tbase_array tbase_array_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .cnt_en    (cnt_en),
    .cnt_adv   (cnt_adv),
    .ovf       (ovf_q),
    .flags     (flag_q)
);

// File: tb/tb_tbase_array.sv
module tb_tbase_array;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       idle_i = 1'b0;
    logic       t0_ovf_i = 1'b0;
    logic       ext_cnt_i = 1'b1;
    logic [4:0] ch_in = 5'h1F;
    logic [4:0] ch_out;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = !clk;

    tbase_array dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_i(idle_i),
        .t0_ovf_i(t0_ovf_i), .ext_cnt_i(ext_cnt_i), .ch_in(ch_in), .ch_out(ch_out)
    );

    function automatic logic pwm_exp(input logic [7:0] lo, input logic [7:0] cmp);
        return lo >= cmp;
    endfunction

    function automatic logic [15:0] cnt_after(input logic [15:0] c, input int n);
        return c + 16'(n);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(5'h01, lo);
        rd(5'h02, hi);
        v = {hi, lo};
    endtask

    task automatic setctrl(input logic [7:0] d);
        wr(5'h00, d);
        repeat (2) @(negedge clk);
    endtask

    task automatic setcnt(input logic [15:0] v);
        wr(5'h01, v[7:0]);
        wr(5'h02, v[15:8]);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); t0_ovf_i = 1'b1;
            @(negedge clk); t0_ovf_i = 1'b0;
        end
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_cnt_i = 1'b0;
            repeat (3) @(negedge clk);
            ext_cnt_i = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0]  b, v0, v1, r1, r2;
        logic [15:0] w, model;
        int          n;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), b);
            chk($sformatf("R1 addr %0d", a), 16'(b), 16'h0);
        end
        chk("R1 ch_out", 16'(ch_out), 16'h0);

        // R2 fast source: 48 clocks -> 12 ticks
        setctrl(8'h05);
        rd(5'h01, v0); repeat (47) @(negedge clk); rd(5'h01, v1);
        chk("R2 div4 rate", 16'(8'(v1 - v0)), 16'd12);
        // R2 slow source: 48 clocks -> 4 ticks
        setctrl(8'h01);
        rd(5'h01, v0); repeat (47) @(negedge clk); rd(5'h01, v1);
        chk("R2 div12 rate", 16'(8'(v1 - v0)), 16'd4);
        setctrl(8'h04);
        rd(5'h01, v0); repeat (40) @(negedge clk); rd(5'h01, v1);
        chk("R2 no run no count", 16'(v1), 16'(v0));

        // R3 timer overflow source, random bursts
        setctrl(8'h09);
        setcnt(16'h0000);
        model = 16'h0000;
        for (int k = 0; k < 12; k++) begin
            n = $urandom_range(1, 20);
            pulse(n);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            model = cnt_after(model, n);
            rd16(w);
            chk("R3 overflow pulses", w, model);
        end

        // R6 write wins over tick in the same clock
        setcnt(16'h3410);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h01; reg_wdata = 8'h55; t0_ovf_i = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; t0_ovf_i = 1'b0;
        rd16(w);
        chk("R6 write beats tick", w, 16'h3455);

        // R7 overflow flag
        setcnt(16'hFFFF);
        pulse(1);
        rd16(w);
        chk("R7 wrap to zero", w, 16'h0000);
        rd(5'h00, b); chk("R7 flag set", 16'(b), 16'h0089);
        wr(5'h00, 8'h89); rd(5'h00, b); chk("R7 write one keeps", 16'(b), 16'h0089);
        wr(5'h00, 8'h09); rd(5'h00, b); chk("R7 write zero clears", 16'(b), 16'h0009);
        setcnt(16'hFFFF);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 8'h09; t0_ovf_i = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; t0_ovf_i = 1'b0;
        rd(5'h00, b); chk("R7 set beats clear", 16'(b), 16'h0089);
        wr(5'h00, 8'h09);

        // R5 idle freeze
        setcnt(16'h0100);
        setctrl(8'h0B);
        idle_i = 1'b1; repeat (2) @(negedge clk);
        pulse(3); rd16(w); chk("R5 frozen in idle", w, 16'h0100);
        idle_i = 1'b0; repeat (2) @(negedge clk);
        pulse(2); rd16(w); chk("R5 resumes", w, 16'h0102);
        setctrl(8'h09);
        idle_i = 1'b1; pulse(1); rd16(w); chk("R5 idle ignored", w, 16'h0103);
        idle_i = 1'b0;

        // R4 external pin source
        setctrl(8'h0D);
        for (int k = 0; k < 4; k++) begin
            setcnt(16'h0000);
            n = $urandom_range(1, 8);
            ext_pulse(n);
            rd16(w);
            chk("R4 pin falls counted", w, 16'(n));
        end
        setcnt(16'h0000);
        @(negedge clk); ext_cnt_i = 1'b0;
        repeat (10) @(negedge clk);
        rd16(w); chk("R4 held low counts once", w, 16'h0001);
        ext_cnt_i = 1'b1; repeat (6) @(negedge clk);
        rd16(w); chk("R4 rise ignored", w, 16'h0001);

        // R8 capture collides with tick
        setctrl(8'h09);
        wr(5'h08, 8'h11);
        setcnt(16'h1234);
        @(negedge clk); ch_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); t0_ovf_i = 1'b1;
        @(negedge clk); t0_ovf_i = 1'b0;
        rd(5'h09, r1); rd(5'h0A, r2);
        chk("R8 capture pre-tick value", {r2, r1}, 16'h1234);
        rd16(w); chk("R8 counter after tick", w, 16'h1235);
        rd(5'h03, b); chk("R8 flag set", 16'(b), 16'h0001);
        setcnt(16'h0500);
        ch_in[0] = 1'b1; repeat (5) @(negedge clk);
        rd(5'h09, r1); rd(5'h0A, r2);
        chk("R8 disabled edge ignored", {r2, r1}, 16'h1234);
        wr(5'h0C, 8'h09);
        ch_in[1] = 1'b0; repeat (5) @(negedge clk);
        setcnt(16'h0777);
        ch_in[1] = 1'b1; repeat (5) @(negedge clk);
        rd(5'h0D, r1); rd(5'h0E, r2);
        chk("R8 rising capture", {r2, r1}, 16'h0777);

        // R11 flag clear semantics
        rd(5'h03, b); chk("R11 two flags", 16'(b), 16'h0003);
        wr(5'h03, 8'hFE); rd(5'h03, b); chk("R11 clear bit0 only", 16'(b), 16'h0002);
        wr(5'h03, 8'h00); rd(5'h03, b); chk("R11 clear all", 16'(b), 16'h0000);

        // R9 match and toggle
        wr(5'h10, 8'h23); wr(5'h11, 8'h10); wr(5'h12, 8'h20);
        setcnt(16'h200D);
        pulse(3);
        rd(5'h03, b); chk("R9 toggle match flag", 16'(b), 16'h0004);
        chk("R9 toggle pin", 16'(ch_out[2]), 16'h1);
        pulse(1);
        chk("R9 pin holds after", 16'(ch_out[2]), 16'h1);
        wr(5'h14, 8'h03); wr(5'h15, 8'h13); wr(5'h16, 8'h20);
        wr(5'h18, 8'h22); wr(5'h19, 8'h15); wr(5'h1A, 8'h20);
        wr(5'h03, 8'h00);
        pulse(4);
        rd(5'h03, b); chk("R9 enable gates match", 16'(b), 16'h0010);
        chk("R9 no toggle without enable", 16'(ch_out[3]), 16'h0);
        chk("R9 match-only no toggle", 16'(ch_out[4]), 16'h0);
        setcnt(16'h200F);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h03; reg_wdata = 8'h00; t0_ovf_i = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; t0_ovf_i = 1'b0;
        rd(5'h03, b); chk("R11 set beats clear", 16'(b), 16'h0004);
        chk("R9 second toggle", 16'(ch_out[2]), 16'h0);

        // R10 PWM
        wr(5'h18, 8'h04);
        setctrl(8'h08);
        for (int k = 0; k < 16; k++) begin
            r1 = 8'($urandom);
            r2 = (k < 3) ? r1 : 8'($urandom);
            wr(5'h19, r1);
            wr(5'h01, r2);
            @(negedge clk);
            chk("R10 pwm level", 16'(ch_out[4]), 16'(pwm_exp(r2, r1)));
        end
        setctrl(8'h09);
        wr(5'h1A, 8'h80); wr(5'h19, 8'h20);
        setcnt(16'h00FE);
        pulse(1);
        rd(5'h19, b); chk("R10 no reload mid-period", 16'(b), 16'h0020);
        pulse(1);
        rd(5'h19, b); chk("R10 reload on wrap", 16'(b), 16'h0080);
        chk("R10 low after reload", 16'(ch_out[4]), 16'h0);

        report();
    end

endmodule